// File: doc/BRIEF.md
# Buffered Crossbar Ingress Queue Scheduler

This block is the arbiter for a single input port of an N-port crossbar switch that has a small buffer at every crosspoint. The input keeps one virtual output queue per output. On each cell-slot strobe the block chooses one queue whose head cell may move into this input's crosspoint buffer for that queue's output. It also raises a remove-request toward the output that the chosen cell is headed for.

A queue is a candidate only when it holds a cell and its crosspoint buffer has room. The choice is made in two tiers. The first tier serves a candidate whose output column has no buffered cells at all, in any of its crosspoint buffers. Such an output is idle, so feeding it first keeps outputs busy. If no candidate has an empty column, a rotating-pointer round-robin over all candidates decides. A single priority pointer feeds both tiers. After every grant the pointer moves one place past the winner.

The decision is registered. The grant, valid flag and remove-request are valid for the one cycle after the strobe edge and are low in every other cycle.

Top module: `xbar_ingress_sched`

## Requirements
- R1: Queue q is eligible only when voq_nonempty[q] is 1 and xpt_full[q] is 0. A queue that is not eligible is never granted.
- R2: Output column o counts as empty when every bit xpt_empty[o*N + i] is 1, for i = 0..N-1. If any eligible queue q has column q empty, the grant goes to one such queue, whatever the pointer position.
- R3: If no eligible queue has an empty column, the grant goes to the first eligible queue found when searching upward from the pointer, wrapping from N-1 back to 0.
- R4: After any grant to queue w, the pointer becomes (w+1) mod N.
- R5: When several eligible queues have empty columns, the winner is the first of them found when searching upward from the pointer, with wrap.
- R6: On a strobe with no eligible queue, grant_valid is 0, grant and rmv_req are all zeros, and the pointer keeps its value.
- R7: A decision is taken only at a rising clock edge where slot_tick is 1. Its results are visible in the cycle after that edge, and grant is one-hot when grant_valid is 1. After an edge where slot_tick is 0, grant_valid is 0, grant is zero, and the pointer does not change.
- R8: rmv_req is one-hot, with its bit at the granted queue's output index, whenever grant_valid is 1. Otherwise it is zero, so at most one remove-request is issued per slot.
- R9: While rst_n is 0 (active low), the pointer is set to 0 and grant, grant_valid and rmv_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_tick | input | 1 | Cell-slot strobe; a decision is taken at an edge where it is high |
| voq_nonempty | input | N | Bit q is high when virtual output queue q holds a cell |
| xpt_full | input | N | Bit q is high when this input's crosspoint buffer toward output q is full |
| xpt_empty | input | N*N | Bit o*N+i is high when the crosspoint buffer from input i to output o is empty |
| grant | output | N | One-hot selected queue, registered |
| grant_valid | output | 1 | A grant was made in the last slot |
| rmv_req | output | N | One-hot remove-request toward the granted output |

## Verification
The bench targets several corner cases:
- An empty column whose queue is blocked, either because the queue has no cell or because its buffer is full. A design that ignores eligibility in the first tier would grant that blocked queue.
- Two empty columns on opposite sides of the pointer. A design that searches the empty-column tier from index 0 instead of from the pointer would pick the wrong one.
- Pointer wrap from N-1 to 0, and a strobe with nothing eligible followed by a round-robin decision. The second decision shows whether the pointer wrongly moved or reset.
- Cycles without a strobe. These expose a design that leaves a stale grant asserted.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;

    // Which selection tier produced the registered decision.
    typedef enum logic [1:0] {
        TIER_NONE  = 2'd0,
        TIER_EMPTY = 2'd1,
        TIER_RR    = 2'd2
    } sched_tier_e;

endpackage

// File: rtl/xbar_col_empty.sv
module xbar_col_empty #(
    parameter int N = 4
) (
    input  logic [N*N-1:0] xpt_empty,
    output logic [N-1:0]   col_empty
);

    // Column o is idle when every crosspoint buffer feeding output o is empty.
    for (genvar o = 0; o < N; o++) begin : g_col
        assign col_empty[o] = &xpt_empty[o*N +: N];
    end

endmodule

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [PW-1:0] idx
);

    // Search upward from the pointer, wrapping, and take the first request.
    always_comb begin
        int unsigned j;
        gnt = '0;
        any = 1'b0;
        idx = '0;
        j   = 0;
        for (int k = 0; k < N; k++) begin
            j = (int'(ptr) + k) % N;
            if (!any && req[j]) begin
                any    = 1'b1;
                gnt[j] = 1'b1;
                idx    = PW'(j);
            end
        end
    end

    // R7: a winner exists exactly when some request is raised, and it is one-hot.
    always_comb begin
        a_r7_pick_onehot: assert (!any || ($countones(gnt) == 1 && (gnt & req) == gnt));
    end

endmodule

// File: rtl/xbar_ingress_sched.sv
module xbar_ingress_sched
    import xbar_sched_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_tick,
    input  logic [N-1:0]   voq_nonempty,
    input  logic [N-1:0]   xpt_full,
    input  logic [N*N-1:0] xpt_empty,
    output logic [N-1:0]   grant,
    output logic           grant_valid,
    output logic [N-1:0]   rmv_req
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [N-1:0]  grant;
        logic          valid;
        logic [N-1:0]  rmv;
        sched_tier_e   tier;
    } sched_state_t;

    sched_state_t s_d, s_q;

    logic [N-1:0]  col_empty_w;
    logic [N-1:0]  elig_w;
    logic [N-1:0]  ecf_req_w;
    logic [N-1:0]  ecf_gnt_w, rr_gnt_w;
    logic          ecf_any_w, rr_any_w;
    logic [PW-1:0] ecf_idx_w, rr_idx_w;

    xbar_col_empty #(.N(N)) u_col (
        .xpt_empty (xpt_empty),
        .col_empty (col_empty_w)
    );

    assign elig_w    = voq_nonempty & ~xpt_full;
    assign ecf_req_w = elig_w & col_empty_w;

    // Tier one: eligible queues whose output column is idle.
    xbar_rr_pick #(.N(N), .PW(PW)) u_pick_empty (
        .req (ecf_req_w),
        .ptr (s_q.ptr),
        .gnt (ecf_gnt_w),
        .any (ecf_any_w),
        .idx (ecf_idx_w)
    );

    // Tier two: plain round-robin over every eligible queue.
    xbar_rr_pick #(.N(N), .PW(PW)) u_pick_rr (
        .req (elig_w),
        .ptr (s_q.ptr),
        .gnt (rr_gnt_w),
        .any (rr_any_w),
        .idx (rr_idx_w)
    );

    always_comb begin
        logic [PW-1:0] win_idx;
        s_d       = s_q;
        s_d.grant = '0;
        s_d.valid = 1'b0;
        s_d.rmv   = '0;
        s_d.tier  = TIER_NONE;
        win_idx   = ecf_any_w ? ecf_idx_w : rr_idx_w;
        if (slot_tick && rr_any_w) begin
            s_d.grant        = ecf_any_w ? ecf_gnt_w : rr_gnt_w;
            s_d.valid        = 1'b1;
            s_d.rmv[win_idx] = 1'b1;
            s_d.ptr          = PW'((int'(win_idx) + 1) % N);
            s_d.tier         = ecf_any_w ? TIER_EMPTY : TIER_RR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ptr: '0, grant: '0, valid: 1'b0, rmv: '0, tier: TIER_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign grant       = s_q.grant;
    assign grant_valid = s_q.valid;
    assign rmv_req     = s_q.rmv;

    // R1: a granted queue was non-empty with room at the strobe edge.
    a_r1_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        s_d.valid |=> ((grant & $past(voq_nonempty & ~xpt_full)) == grant));

    // R2: an eligible idle column takes precedence over plain round-robin.
    a_r2_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && (ecf_req_w != '0)) |=> ((grant & $past(ecf_req_w)) != '0));

    // R4: the pointer sits one place past the granted queue.
    a_r4_ptr_after: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant[(s_q.ptr == '0) ? N-1 : int'(s_q.ptr) - 1]);

    // R6: no grant bits without a valid decision.
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0 && rmv_req == '0));

    // R7: no strobe means no decision and no pointer movement.
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> (!grant_valid && $stable(s_q.ptr)));

    // R8: one remove-request, aimed at the granted output.
    a_r8_rmv_match: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(rmv_req) == 1 && rmv_req == grant));

endmodule

// File: tb/xbar_ingress_sched_bench.sv
`timescale 1ns/1ps
module xbar_ingress_sched_bench;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           slot_tick = 1'b0;
    logic [N-1:0]   voq_nonempty = '0;
    logic [N-1:0]   xpt_full = '0;
    logic [N*N-1:0] xpt_empty = '0;
    logic [N-1:0]   grant;
    logic           grant_valid;
    logic [N-1:0]   rmv_req;

    int checks = 0;
    int failures = 0;
    int m_ptr = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic         valid;
        logic [N-1:0] gnt;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    xbar_ingress_sched #(.N(N)) u_xbar_ingress_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_tick    (slot_tick),
        .voq_nonempty (voq_nonempty),
        .xpt_full     (xpt_full),
        .xpt_empty    (xpt_empty),
        .grant        (grant),
        .grant_valid  (grant_valid),
        .rmv_req      (rmv_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference decision built from the requirement text.
    task automatic drive_slot(input logic [N-1:0] ne, input logic [N-1:0] fu,
                              input logic [N*N-1:0] em, input string tag);
        logic [N-1:0] elig, ecf, pool;
        exp_t e;
        elig = ne & ~fu;
        ecf  = '0;
        for (int o = 0; o < N; o++) ecf[o] = elig[o] & (&em[o*N +: N]);
        pool = (ecf != '0) ? ecf : elig;
        e.valid = 1'b0;
        e.gnt   = '0;
        e.tag   = tag;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr + k) % N;
            if (!e.valid && pool[j]) begin
                e.valid = 1'b1;
                e.gnt[j] = 1'b1;
                m_ptr = (j + 1) % N;
            end
        end
        @(negedge clk);
        voq_nonempty = ne;
        xpt_full     = fu;
        xpt_empty    = em;
        sb.push_back(e);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [N*N-1:0] cols_empty(input logic [N-1:0] cols);
        logic [N*N-1:0] m;
        m = '0;
        for (int o = 0; o < N; o++) if (cols[o]) m[o*N +: N] = '1;
        return m;
    endfunction

    // Monitor: compares each registered decision with the scoreboard.
    initial begin
        forever begin
            bit ticked;
            @(posedge clk);
            ticked = slot_tick;
            @(negedge clk);
            if (mon_en) begin
                if (ticked) begin
                    exp_t e;
                    if (sb.size() == 0) begin
                        check("R7 scoreboard underflow", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check({e.tag, " valid"}, grant_valid, e.valid);
                        check({e.tag, " grant"}, grant, e.gnt);
                        check({"R8 rmv_req ", e.tag}, rmv_req, e.gnt);
                    end
                end else begin
                    check("R7 idle valid", grant_valid, 0);
                    check("R7 idle grant", grant, 0);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9 valid in reset", grant_valid, 0);
        check("R9 grant in reset", grant, 0);
        check("R9 rmv in reset", rmv_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R3: only queue 2 eligible, no idle column
        drive_slot(4'b0100, 4'b0000, '0, "R3 single");
        // R4: pointer at 3, all eligible -> 3, then wrap to 0
        drive_slot(4'b1111, 4'b0000, '0, "R4 wrap");
        // R1: queues 0,1 full -> skip to 2
        drive_slot(4'b1111, 4'b0011, '0, "R1 full skip");
        // R1: queue empty but buffer free is not eligible
        drive_slot(4'b0110, 4'b0000, '0, "R1 empty queue");
        // R2: column 1 idle beats pointer
        drive_slot(4'b1111, 4'b0000, cols_empty(4'b0010), "R2 idle column");
        // R5: columns 0 and 3 idle, search from pointer
        drive_slot(4'b1111, 4'b0000, cols_empty(4'b1001), "R5 pick from ptr");
        drive_slot(4'b1111, 4'b0000, cols_empty(4'b1001), "R5 second pick");
        // R2: idle column 2 with no cell falls back to round-robin
        drive_slot(4'b1011, 4'b0000, cols_empty(4'b0100), "R2 blocked idle column");
        // R6: nothing eligible, pointer must hold
        drive_slot(4'b0011, 4'b0011, cols_empty(4'b1111), "R6 none eligible");
        drive_slot(4'b1111, 4'b0000, '0, "R6 ptr held");
        // R4 for the idle-column tier: pointer moves past winner 0
        drive_slot(4'b1111, 4'b0000, cols_empty(4'b0001), "R4 idle tier ptr");
        drive_slot(4'b1111, 4'b0000, '0, "R4 after idle tier");

        // Mixed patterns
        for (int t = 0; t < 300; t++) begin
            logic [N*N-1:0] em;
            em = '0;
            for (int b = 0; b < N*N; b++) em[b] = ($urandom % 5) != 0;
            drive_slot(N'($urandom), N'($urandom) & N'($urandom), em, "R3 mixed");
        end

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule